// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory holding 2048 bytes. It oversamples the clock and data lines with the system clock, picks out start and stop conditions, and runs a byte-level protocol engine. The engine receives a select byte and a low address byte, acknowledges what it accepts, and stores into or reads from an internal byte array. It supports single-byte writes, page writes that stay inside a 16-byte page, reads at the current address, reads at an address the master sets, and sequential reads that run through the whole array.

The data line is open-drain. The block never drives it high. It only requests a pull-down through `sda_pull`, and the pad or bench combines that with the bus pull-up. A write-protect input makes the whole array read-only. After every stop that closes a write, a busy window of a programmable number of system clocks models the self-timed programming cycle. During that window the block does not answer its select byte.

The upper three address bits travel in the select byte, so there are no address-strap inputs and only one such slave can sit on a bus.

Top module: `ee2w_slave`

## Requirements
- R1: A fall of SDA while SCL is high is a start condition. It aborts any transfer in progress and begins reception of a select byte, including a repeated start in the middle of a transaction.
- R2: The select byte is sent MSB first and holds the prefix 1010, then address bits A10..A8, then a direction bit in bit 0 (1 = read). A matching byte is acknowledged by pulling SDA low during the ninth SCL clock. A byte with any other prefix is not acknowledged, and the bus is ignored until the next start.
- R3: The block only ever pulls SDA low, changes its drive only while SCL is low, and sends read data MSB first, with each bit set up after an SCL fall.
- R4: A write select byte, an address byte holding A7..A0, and a data byte are each acknowledged, and the data byte is stored at the 11-bit address.
- R5: During a page write, each further data byte goes to the next address with only the low 4 bits incremented, so the address wraps inside its 16-byte page.
- R6: A write select byte plus an address byte, followed by a repeated start and a read select byte, returns the byte stored at that address.
- R7: When the master acknowledges a read byte, the next byte comes from the next address, and address 2047 is followed by address 0.
- R8: A read select byte with no preceding address returns the byte at the internal address, which is one past the last byte written or read.
- R9: When the master does not acknowledge a read byte, the block releases SDA and ignores further clocks until a start condition.
- R10: While `wp` is high, data bytes are still acknowledged, but the array keeps its contents and no busy window starts.
- R11: A stop that follows at least one stored data byte starts a busy window of WRITE_CYCLES clocks. During that window the select byte is not acknowledged, and after it the select byte is acknowledged again.
- R12: While `rst_n` is low, SDA is released. After reset the internal address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock line from the bus master |
| sda_in | input | 1 | Level of the shared data line |
| wp | input | 1 | Write protect; high makes the array read-only |
| sda_pull | output | 1 | High requests a pull-down of the data line |

## Verification
On every cycle, the assertions check that the pull-down request changes only while SCL is low and that it is released whenever the engine is idle. They also check that a start always leads into select-byte reception, that a page write never disturbs the upper address bits, and that the busy window opens only on a stop and never overlaps a select acknowledge. The bench scenarios are what show the data paths: the stored bytes, the page wrap, the array rollover in sequential reads, the current-address pointer, the effect of write protect on array contents, and the moment the busy window closes.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEV   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4
  } ee2w_state_t;

  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_ACK  = 4'd9;
endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES:0] scl_p;
  logic [STAGES:0] sda_p;
  logic scl_cur, scl_prev, sda_cur, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_raw};
      sda_p <= {sda_p[STAGES-1:0], sda_raw};
    end
  end

  assign scl_cur  = scl_p[STAGES-1];
  assign scl_prev = scl_p[STAGES];
  assign sda_cur  = sda_p[STAGES-1];
  assign sda_prev = sda_p[STAGES];

  assign sda_s     = sda_cur;
  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_evt = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_evt  = scl_cur & scl_prev & ~sda_prev & sda_cur;
endmodule

// File: rtl/ee2w_mem.sv
module ee2w_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ee2w_busy_timer.sv
module ee2w_busy_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (go)                cnt_d = LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
  parameter int         ADDR_W       = 11,
  parameter int         PAGE_W       = 4,
  parameter int         WRITE_CYCLES = 625000,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [3:0] DEV_CODE     = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda_in,
  input  logic wp,
  output logic sda_pull
);
  import ee2w_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, timer_go;
  logic mem_we;
  logic [7:0] rdata;

  ee2w_state_t state_q, state_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [7:0]        tx_q, tx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rw_q, rw_d;
  logic              ack_q, ack_d;
  logic              dout_q, dout_d;
  logic              pend_q, pend_d;

  ee2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl), .sda_raw(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ee2w_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(shreg_q),
    .raddr(addr_q), .rdata(rdata)
  );

  ee2w_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(timer_go), .busy(busy)
  );

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    tx_d     = tx_q;
    addr_d   = addr_q;
    rw_d     = rw_q;
    ack_d    = ack_q;
    dout_d   = dout_q;
    pend_d   = pend_q;
    mem_we   = 1'b0;
    timer_go = 1'b0;

    if (start_evt) begin
      state_d  = ST_DEV;
      bitcnt_d = '0;
      ack_d    = 1'b0;
      dout_d   = 1'b0;
    end else if (stop_evt) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      ack_d    = 1'b0;
      dout_d   = 1'b0;
      if (pend_q) begin
        timer_go = 1'b1;
        pend_d   = 1'b0;
      end
    end else begin
      unique case (state_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitcnt_q < BIT_LAST) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 1'b1;
          end
          if (scl_fall && bitcnt_q == BIT_LAST) begin
            bitcnt_d = BIT_ACK;
            if (state_q == ST_DEV) begin
              if (shreg_q[7:4] == DEV_CODE && !busy) begin
                ack_d = 1'b1;
                rw_d  = shreg_q[0];
                if (!shreg_q[0]) addr_d[ADDR_W-1:8] = shreg_q[HI_W:1];
              end else begin
                state_d  = ST_IDLE;
                bitcnt_d = '0;
              end
            end else if (state_q == ST_ADDR) begin
              ack_d       = 1'b1;
              addr_d[7:0] = shreg_q;
            end else begin
              ack_d = 1'b1;
              if (!wp) begin
                mem_we               = 1'b1;
                pend_d               = 1'b1;
                addr_d[PAGE_W-1:0]   = addr_q[PAGE_W-1:0] + 1'b1;
              end
            end
          end
          if (scl_fall && bitcnt_q == BIT_ACK) begin
            ack_d    = 1'b0;
            bitcnt_d = '0;
            if (state_q == ST_DEV) begin
              if (rw_q) begin
                state_d = ST_RDATA;
                tx_d    = rdata;
                dout_d  = ~rdata[7];
                addr_d  = addr_q + 1'b1;
              end else begin
                state_d = ST_ADDR;
              end
            end else if (state_q == ST_ADDR) begin
              state_d = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            if (bitcnt_q < BIT_LAST) begin
              bitcnt_d = bitcnt_q + 1'b1;
            end else if (bitcnt_q == BIT_ACK && sda_s) begin
              state_d  = ST_IDLE;
              bitcnt_d = '0;
            end
          end
          if (scl_fall) begin
            if (bitcnt_q != '0 && bitcnt_q < BIT_LAST) begin
              dout_d = ~tx_q[6];
              tx_d   = {tx_q[6:0], 1'b0};
            end else if (bitcnt_q == BIT_LAST) begin
              dout_d   = 1'b0;
              bitcnt_d = BIT_ACK;
            end else if (bitcnt_q == BIT_ACK) begin
              tx_d     = rdata;
              dout_d   = ~rdata[7];
              addr_d   = addr_q + 1'b1;
              bitcnt_d = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      rw_q     <= 1'b0;
      ack_q    <= 1'b0;
      dout_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      tx_q     <= tx_d;
      addr_q   <= addr_d;
      rw_q     <= rw_d;
      ack_q    <= ack_d;
      dout_q   <= dout_d;
      pend_q   <= pend_d;
    end
  end

  assign sda_pull = ack_q | dout_q;
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl,
  input logic                  sda_pull,
  input ee2w_pkg::ee2w_state_t state_q,
  input logic [ADDR_W-1:0]     addr_q,
  input logic                  ack_q,
  input logic                  busy,
  input logic                  start_evt,
  input logic                  stop_evt
);
  import ee2w_pkg::*;

  a_r3_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl);

  a_r1_start_enters_select: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_DEV) && !sda_pull);

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull);

  a_r5_page_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDATA) |=> (state_q != ST_WDATA) ||
      (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));

  a_r11_busy_opens_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  a_r11_no_select_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DEV) && $rose(ack_q)) |-> !busy);
endmodule

bind ee2w_slave ee2w_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_pull(sda_pull),
  .state_q(state_q), .addr_q(addr_q), .ack_q(ack_q), .busy(busy),
  .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/ee2w_slave_bench.sv
module ee2w_slave_bench;
  localparam int WCYC = 400;
  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {11'h000, 8'h3C}, {11'h7FF, 8'hC3}, {11'h123, 8'h5A}, {11'h124, 8'hA5},
    {11'h2F0, 8'h11}, {11'h555, 8'hAA}, {11'h0AA, 8'h1E}, {11'h400, 8'h81}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, m_scl, m_sdal, wp;
  logic sda_bus;
  logic sda_pull;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign sda_bus = ~(m_sdal | sda_pull);

  ee2w_slave #(.WRITE_CYCLES(WCYC)) u_ee2w_slave (
    .clk(clk), .rst_n(rst_n), .scl(m_scl), .sda_in(sda_bus),
    .wp(wp), .sda_pull(sda_pull)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c;
    m_sdal = 1'b0; w(5); m_scl = 1'b1; w(10); m_sdal = 1'b1; w(10); m_scl = 1'b0; w(5);
  endtask

  task automatic stop_c;
    m_sdal = 1'b1; w(5); m_scl = 1'b1; w(10); m_sdal = 1'b0; w(10);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sdal = ~b[i]; w(5); m_scl = 1'b1; w(10); m_scl = 1'b0; w(5);
    end
    m_sdal = 1'b0; w(5); m_scl = 1'b1; w(5); acked = ~sda_bus; w(5); m_scl = 1'b0; w(5);
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sdal = 1'b0; w(5); m_scl = 1'b1; w(5); b[i] = sda_bus; w(5); m_scl = 1'b0; w(5);
    end
    m_sdal = mack; w(5); m_scl = 1'b1; w(10); m_scl = 1'b0; w(5); m_sdal = 1'b0;
  endtask

  function automatic logic [7:0] sel(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic byte_write(input logic [10:0] a, input logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    start_c;
    tx_byte(sel(a, 1'b0), k1);
    tx_byte(a[7:0], k2);
    tx_byte(d, k3);
    stop_c;
    ok = k1 & k2 & k3;
  endtask

  task automatic rand_read(input logic [10:0] a, input int n,
                           output logic [7:0] d0, output logic [7:0] d1);
    logic k;
    start_c;
    tx_byte(sel(a, 1'b0), k);
    tx_byte(a[7:0], k);
    start_c;
    tx_byte(sel(a, 1'b1), k);
    rx_byte(n > 1, d0);
    d1 = 8'h00;
    if (n > 1) rx_byte(1'b0, d1);
    stop_c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [7:0] d0, d1;

    rst_n = 1'b0; m_scl = 1'b1; m_sdal = 1'b0; wp = 1'b0;
    w(10);
    chk("R12 sda released in reset", {15'd0, sda_pull}, 16'd0);
    rst_n = 1'b1;
    w(10);

    for (int i = 0; i < NVEC; i++) begin
      byte_write(VEC[i][18:8], VEC[i][7:0], ok);
      chk("R4 byte write acks", {15'd0, ok}, 16'd1);
      w(WCYC + 50);
    end
    for (int i = 0; i < NVEC; i++) begin
      rand_read(VEC[i][18:8], 1, d0, d1);
      chk("R6 random read data", {8'd0, d0}, {8'd0, VEC[i][7:0]});
    end

    rand_read(11'h0AA, 1, d0, d1);
    chk("R3 MSB first", {8'd0, d0}, 16'h001E);

    // R8: write 0x123 then read at the current pointer (0x124)
    byte_write(11'h123, 8'h5A, ok);
    w(WCYC + 50);
    start_c; tx_byte(8'hA1, k); rx_byte(1'b0, d0); stop_c;
    chk("R8 current address read", {8'd0, d0}, 16'h00A5);

    // R11 busy window
    byte_write(11'h2F0, 8'h11, ok);
    start_c; tx_byte(sel(11'h2F0, 1'b0), k); stop_c;
    chk("R11 select not acked while busy", {15'd0, k}, 16'd0);
    w(WCYC + 50);
    start_c; tx_byte(sel(11'h2F0, 1'b0), k); stop_c;
    chk("R11 select acked after busy", {15'd0, k}, 16'd1);

    // R5 page write wrapping from 0x35E
    start_c;
    tx_byte(sel(11'h35E, 1'b0), k);
    tx_byte(8'h5E, k);
    for (int i = 0; i < 4; i++) begin
      tx_byte(8'hD0 + 8'(i), k);
      chk("R5 page data ack", {15'd0, k}, 16'd1);
    end
    stop_c;
    w(WCYC + 50);
    rand_read(11'h350, 2, d0, d1);
    chk("R5 wrapped byte 2", {d0, d1}, 16'hD2D3);
    rand_read(11'h35E, 2, d0, d1);
    chk("R5 page head bytes", {d0, d1}, 16'hD0D1);

    // R7 sequential read rolls over
    rand_read(11'h7FF, 2, d0, d1);
    chk("R7 rollover 7FF to 000", {d0, d1}, 16'hC33C);

    // R10 write protect
    wp = 1'b1;
    byte_write(11'h555, 8'h00, ok);
    chk("R10 protected write acked", {15'd0, ok}, 16'd1);
    start_c; tx_byte(sel(11'h555, 1'b0), k); stop_c;
    chk("R10 no busy window", {15'd0, k}, 16'd1);
    rand_read(11'h555, 1, d0, d1);
    chk("R10 array unchanged", {8'd0, d0}, 16'h00AA);
    wp = 1'b0;

    // R2 wrong prefix ignored
    start_c;
    tx_byte(8'hE0, k);
    chk("R2 wrong prefix nack", {15'd0, k}, 16'd0);
    tx_byte(8'h00, k);
    chk("R2 later byte ignored", {15'd0, k}, 16'd0);
    stop_c;

    // R9 master nack releases the line
    start_c; tx_byte(8'hA1, k); rx_byte(1'b0, d0); rx_byte(1'b0, d1); stop_c;
    chk("R9 line released after nack", {8'd0, d1}, 16'h00FF);

    // R1 repeated start aborts a write before data
    start_c;
    tx_byte(sel(11'h400, 1'b0), k);
    tx_byte(8'h00, k);
    start_c;
    tx_byte(sel(11'h400, 1'b1), k);
    chk("R1 select after repeated start", {15'd0, k}, 16'd1);
    rx_byte(1'b0, d0);
    stop_c;
    chk("R1 aborted write left data", {8'd0, d0}, 16'h0081);

    // R12 reset clears the pointer
    rst_n = 1'b0; w(5); rst_n = 1'b1; w(10);
    start_c; tx_byte(8'hA1, k); rx_byte(1'b0, d0); stop_c;
    chk("R12 pointer zero after reset", {8'd0, d0}, 16'h003C);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule